// File: doc/BRIEF.md
# Position-Priority Issue Select Tree

This block decides, once per cycle, which entries of an instruction window are sent to a group of identical functional units. Every window entry that is ready raises one request line. For each unit, a tree of four-input arbiter cells merges these requests. Each cell sends a "something below me is requesting" signal toward the root. Each cell passes a grant back down only when its parent has enabled it. The root of each tree is enabled only while its unit can accept work. Because a cell always favours its lowest-numbered input, the winner is the requesting entry with the smallest window index. The depth of a tree is the base-4 logarithm of the window size.

More than one unit is handled by placing trees in series. The second tree receives the request vector with the first tree's winner removed, the third tree receives it with the first two winners removed, and so on. A unit that is unavailable grants nothing, so its would-be winner stays in the vector for the next unit in the chain. Grants are captured in a register, so the grants visible on the output correspond to the requests and availability sampled at the previous clock edge.

Top module: `tree_issue_select`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is asserted asynchronously, every grant output bit is 0.
- R2: The grant slice of each unit has at most one bit set.
- R3: When unit 0 is available, it grants the requesting entry with the lowest index. The slice of unit u is grantVec[u*NUM_ENTRIES +: NUM_ENTRIES], and bit i of a slice stands for window entry i.
- R4: Unit u grants the lowest-index requesting entry that no lower-numbered unit granted in the same cycle, provided unit u is available.
- R5: A unit whose availability bit (unitAvail[u]) is 0 asserts no grant.
- R6: When no entry requests, no grant is asserted.
- R7: No window entry is granted to two units in the same cycle.
- R8: A grant is only ever given to an entry whose request was set.
- R9: Grants appear one clock edge after the requests and availability that produced them, and they hold steady until the next edge.
- R10: The total number of grants in a cycle equals the smaller of the number of requests and the number of available units.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqVec | input | NUM_ENTRIES | One ready/request line per window entry |
| unitAvail | input | NUM_UNITS | Bit u is 1 when functional unit u can accept an instruction |
| grantVec | output | NUM_UNITS*NUM_ENTRIES | Registered one-hot grant per unit, one slice of NUM_ENTRIES bits per unit |

## Verification
Suppose a cell favours the wrong input, or a level of the tree drops its enable. The effect appears in the very next registered grant as a winner that is not the lowest requester, which the fixed-vector table catches across subtree boundaries. A mask in the chain that fails to remove an earlier winner shows up, in the same cycle, as the same entry granted to two units, or as too few grants for the available units. A root enable that ignores availability shows up as a grant from a unit that is marked unavailable. The pseudo-random sweep compares every cycle against an independent lowest-index model, so a discrepancy is reported one cycle after the stimulus that exposes it.

// File: rtl/tree_sel_pkg.sv
package tree_sel_pkg;

  // Widest unit chain the strobe struct can carry.
  localparam int SEL_MAX_UNITS = 8;

  // Strobes from control to datapath.
  typedef struct packed {
    logic [SEL_MAX_UNITS-1:0] rootEn;   // root enable per select tree
    logic                     loadGrant; // capture new grants this edge
  } selStrobe_t;

  // Number of four-input levels needed to cover n entries.
  function automatic int selLevels(input int n);
    int lvl;
    int cap;
    lvl = 1;
    cap = 4;
    while (cap < n) begin
      cap = cap * 4;
      lvl = lvl + 1;
    end
    return lvl;
  endfunction

endpackage

// File: rtl/tree_sel_cell.sv
// Four-input arbiter cell: lowest input wins, grants only when enabled.
module tree_sel_cell (
  input  logic [3:0] reqIn,
  input  logic       enIn,
  output logic [3:0] grantOut,
  output logic       anyOut
);

  always_comb begin
    logic seenLower;
    seenLower = 1'b0;
    for (int k = 0; k < 4; k++) begin
      grantOut[k] = enIn & reqIn[k] & ~seenLower;
      seenLower   = seenLower | reqIn[k];
    end
  end

  assign anyOut = |reqIn;

endmodule

// File: rtl/tree_sel_tree.sv
// One select tree over the whole window: any-request flows up, enables flow down.
module tree_sel_tree #(
  parameter int NUM_ENTRIES = 16
) (
  input  logic [NUM_ENTRIES-1:0] reqIn,
  input  logic                   rootEn,
  output logic [NUM_ENTRIES-1:0] grantOut,
  output logic                   anyReq
);

  localparam int LEVELS = tree_sel_pkg::selLevels(NUM_ENTRIES);
  localparam int PAD    = 1 << (2 * LEVELS);
  localparam int LEAVES = PAD / 4;

  // anyLvl[0] is the padded request vector; anyLvl[l+1][j] is the any-request of node j at level l.
  // enLvl[LEVELS][0] is the root enable; enLvl[0] holds the leaf grants.
  logic [PAD-1:0] anyLvl [LEVELS+1];
  logic [PAD-1:0] enLvl  [LEVELS+1];

  assign anyLvl[0]     = PAD'(reqIn);
  assign enLvl[LEVELS] = PAD'(rootEn);

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int NODES = PAD >> (2 * (l + 1));
    if (LEAVES < PAD) begin : g_hi
      assign anyLvl[l+1][PAD-1:LEAVES] = '0;
    end
    for (genvar j = 0; j < LEAVES; j++) begin : g_node
      if (j < NODES) begin : g_cell
        tree_sel_cell u_cell (
          .reqIn   (anyLvl[l][4*j +: 4]),
          .enIn    (enLvl[l+1][j]),
          .grantOut(enLvl[l][4*j +: 4]),
          .anyOut  (anyLvl[l+1][j])
        );
      end else begin : g_none
        assign enLvl[l][4*j +: 4] = '0;
        assign anyLvl[l+1][j]     = 1'b0;
      end
    end
  end

  assign grantOut = enLvl[0][NUM_ENTRIES-1:0];
  assign anyReq   = anyLvl[LEVELS][0];

endmodule

// File: rtl/tree_sel_ctrl.sv
// Control: turns unit availability into root enables and the grant load strobe.
module tree_sel_ctrl
  import tree_sel_pkg::*;
#(
  parameter int NUM_UNITS = 2
) (
  input  logic                 rstN,
  input  logic [NUM_UNITS-1:0] unitAvail,
  output selStrobe_t           strobe
);

  always_comb begin
    strobe           = '0;
    strobe.loadGrant = rstN;
    for (int u = 0; u < NUM_UNITS; u++) begin
      strobe.rootEn[u] = unitAvail[u];
    end
  end

endmodule

// File: rtl/tree_sel_dp.sv
// Datapath: chained select trees with earlier winners masked, and the grant register.
module tree_sel_dp
  import tree_sel_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_UNITS   = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_ENTRIES-1:0]           reqVec,
  input  logic [NUM_UNITS-1:0]             unitAvail,
  input  selStrobe_t                       strobe,
  output logic [NUM_UNITS*NUM_ENTRIES-1:0] grantVec
);

  localparam int GW = NUM_UNITS * NUM_ENTRIES;

  // maskedReq[u] is what tree u sees: reqVec minus winners of trees 0..u-1.
  logic [NUM_ENTRIES-1:0] maskedReq [NUM_UNITS+1];
  logic [NUM_ENTRIES-1:0] treeGrant [NUM_UNITS];
  logic [NUM_UNITS-1:0]   treeAny;
  logic [GW-1:0]          grantNext;
  logic [GW-1:0]          grantQ;

  assign maskedReq[0] = reqVec;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    tree_sel_tree #(.NUM_ENTRIES(NUM_ENTRIES)) u_tree (
      .reqIn   (maskedReq[u]),
      .rootEn  (strobe.rootEn[u]),
      .grantOut(treeGrant[u]),
      .anyReq  (treeAny[u])
    );
    assign maskedReq[u+1]                    = maskedReq[u] & ~treeGrant[u];
    assign grantNext[u*NUM_ENTRIES +: NUM_ENTRIES] = treeGrant[u];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantQ <= '0;
    end else if (strobe.loadGrant) begin
      grantQ <= grantNext;
    end
  end

  assign grantVec = grantQ;

  // ---------------- assertions ----------------
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
    // R2: one-hot per unit
    assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(grantQ[u*NUM_ENTRIES +: NUM_ENTRIES]));

    // R5: unavailable unit grants nothing
    assert_unavail_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
      !$past(unitAvail[u]) |-> (grantQ[u*NUM_ENTRIES +: NUM_ENTRIES] == '0));

    // R8: grant only to a requester
    assert_grant_requested_R8: assert property (@(posedge clk) disable iff (!rstN)
      (grantQ[u*NUM_ENTRIES +: NUM_ENTRIES] & ~$past(reqVec)) == '0);

    // R6: no requests, no grant
    assert_no_req_no_grant_R6: assert property (@(posedge clk) disable iff (!rstN)
      ($past(reqVec) == '0) |-> (grantQ[u*NUM_ENTRIES +: NUM_ENTRIES] == '0));
  end

  // R3: unit 0 winner has no lower-index requester
  assert_lowest_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    (grantQ[NUM_ENTRIES-1:0] != '0) |->
      (($past(reqVec) & (grantQ[NUM_ENTRIES-1:0] - 1'b1)) == '0));

  // R7: no entry granted twice
  always_comb begin
    logic [NUM_ENTRIES-1:0] seen;
    seen = '0;
    if (rstN) begin
      for (int u = 0; u < NUM_UNITS; u++) begin
        assert_no_double_grant_R7: assert ((seen & grantQ[u*NUM_ENTRIES +: NUM_ENTRIES]) == '0);
        seen = seen | grantQ[u*NUM_ENTRIES +: NUM_ENTRIES];
      end
    end
  end

  // Tree any-request must agree with the vector it was fed.
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_any
    assert_tree_any_R6: assert property (@(posedge clk) disable iff (!rstN)
      treeAny[u] == (maskedReq[u] != '0));
  end

endmodule

// File: rtl/tree_issue_select.sv
// Thin top: control strobes into the chained-tree datapath.
module tree_issue_select
  import tree_sel_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_UNITS   = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_ENTRIES-1:0]           reqVec,
  input  logic [NUM_UNITS-1:0]             unitAvail,
  output logic [NUM_UNITS*NUM_ENTRIES-1:0] grantVec
);

  selStrobe_t strobe;

  tree_sel_ctrl #(.NUM_UNITS(NUM_UNITS)) u_ctrl (
    .rstN     (rstN),
    .unitAvail(unitAvail),
    .strobe   (strobe)
  );

  tree_sel_dp #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_UNITS(NUM_UNITS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqVec   (reqVec),
    .unitAvail(unitAvail),
    .strobe   (strobe),
    .grantVec (grantVec)
  );

endmodule

// File: tb/tree_issue_select_tb.sv
module tree_issue_select_tb;

  localparam int N = 16;
  localparam int U = 2;

  typedef struct packed {
    logic [15:0] req;
    logic [1:0]  avail;
    logic [15:0] g0;
    logic [15:0] g1;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 2'b11, 16'h0000, 16'h0000},
    '{16'h0001, 2'b11, 16'h0001, 16'h0000},
    '{16'h8000, 2'b11, 16'h8000, 16'h0000},
    '{16'h8001, 2'b11, 16'h0001, 16'h8000},
    '{16'h00F0, 2'b11, 16'h0010, 16'h0020},
    '{16'h0F00, 2'b01, 16'h0100, 16'h0000},
    '{16'h0F00, 2'b10, 16'h0000, 16'h0100},
    '{16'hFFFF, 2'b00, 16'h0000, 16'h0000},
    '{16'h1010, 2'b11, 16'h0010, 16'h1000},
    '{16'hA000, 2'b11, 16'h2000, 16'h8000},
    '{16'h0048, 2'b11, 16'h0008, 16'h0040},
    '{16'h4000, 2'b11, 16'h4000, 16'h0000},
    '{16'h0006, 2'b10, 16'h0000, 16'h0002}
  };

  logic           clk = 1'b0;
  logic           rstN;
  logic [N-1:0]   reqVec;
  logic [U-1:0]   unitAvail;
  logic [U*N-1:0] grantVec;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  tree_issue_select #(.NUM_ENTRIES(N), .NUM_UNITS(U)) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .reqVec   (reqVec),
    .unitAvail(unitAvail),
    .grantVec (grantVec)
  );

  task automatic checkEq(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Independent model: each available unit takes the lowest remaining request.
  function automatic logic [U*N-1:0] refGrant(input logic [N-1:0] req, input logic [U-1:0] avail);
    logic [N-1:0]   left;
    logic [U*N-1:0] g;
    left = req;
    g    = '0;
    for (int u = 0; u < U; u++) begin
      if (avail[u]) begin
        for (int i = 0; i < N; i++) begin
          if (left[i]) begin
            g[u*N + i] = 1'b1;
            left[i]    = 1'b0;
            break;
          end
        end
      end
    end
    return g;
  endfunction

  function automatic int popc(input logic [31:0] v);
    int c;
    c = 0;
    for (int i = 0; i < 32; i++) c += int'(v[i]);
    return c;
  endfunction

  initial begin
    logic [U*N-1:0] prevG;
    logic [15:0]    lfsr;
    logic [U*N-1:0] expG;
    int             nReq;
    int             nAv;
    int             nExp;

    // R1: reset state with every request raised
    rstN      = 1'b0;
    reqVec    = '1;
    unitAvail = '1;
    repeat (3) @(posedge clk);
    #1;
    checkEq(32'(grantVec), 32'h0, "R1 grants during reset");

    @(negedge clk);
    reqVec = '0;
    rstN   = 1'b1;
    @(posedge clk);
    #1;
    checkEq(32'(grantVec), 32'h0, "R6 idle after reset");
    prevG = '0;

    // Table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      reqVec    = VECS[v].req;
      unitAvail = VECS[v].avail;
      #1;
      checkEq(32'(grantVec), 32'(prevG), "R9 output holds until edge");
      @(posedge clk);
      #1;
      checkEq(32'(grantVec[N-1:0]), 32'(VECS[v].g0), "R3 unit0 lowest requester");
      checkEq(32'(grantVec[2*N-1:N]), 32'(VECS[v].g1), "R4 unit1 next requester");
      if (!VECS[v].avail[0]) checkEq(32'(grantVec[N-1:0]), 32'h0, "R5 unit0 unavailable");
      if (!VECS[v].avail[1]) checkEq(32'(grantVec[2*N-1:N]), 32'h0, "R5 unit1 unavailable");
      if (VECS[v].req == '0) checkEq(32'(grantVec), 32'h0, "R6 no requests");
      checkEq(32'(grantVec[N-1:0] & grantVec[2*N-1:N]), 32'h0, "R7 no shared entry");
      checkEq(32'((grantVec[N-1:0] | grantVec[2*N-1:N]) & ~VECS[v].req), 32'h0, "R8 grant to requester");
      checkEq(32'($countones(grantVec[N-1:0])), 32'($countones(grantVec[N-1:0]) != 0), "R2 one-hot unit0");
      prevG = {VECS[v].g1, VECS[v].g0};
    end

    // Asynchronous reset in mid-run
    @(negedge clk);
    reqVec    = 16'h0300;
    unitAvail = 2'b11;
    @(posedge clk);
    #1;
    checkEq(32'(grantVec), {16'h0200, 16'h0100}, "R3 before async reset");
    #2;
    rstN = 1'b0;
    #1;
    checkEq(32'(grantVec), 32'h0, "R1 async reset clears grants");
    @(negedge clk);
    rstN = 1'b1;

    // Pseudo-random sweep against the model
    lfsr = 16'hACE1;
    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      reqVec    = (t % 5 == 0) ? (lfsr & (lfsr >> 3)) : lfsr;
      unitAvail = (t % 7 == 3) ? lfsr[1:0] : 2'b11;
      expG      = refGrant(reqVec, unitAvail);
      nReq      = popc(32'(reqVec));
      nAv       = popc(32'(unitAvail));
      nExp      = (nReq < nAv) ? nReq : nAv;
      @(posedge clk);
      #1;
      checkEq(32'(grantVec), 32'(expG), "R4 chained select vs model");
      checkEq(32'(popc(32'(grantVec))), 32'(nExp), "R10 grant count");
      checkEq(32'(grantVec[N-1:0] & grantVec[2*N-1:N]), 32'h0, "R7 sweep overlap");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule